// File: doc/BRIEF.md
# Iterative Signed Multiply-Accumulate Unit

This unit performs signed multiplies and multiply-accumulates on two 32-bit source operands. It keeps a single 40-bit accumulator. Operations are handed over through an issue handshake. The unit does not contain a full-width multiplier array. A 32-by-17-bit slice multiplier is reused over one, two or three clock cycles, and the cycle count depends on how many significant bits the second operand carries. Two packed 16-bit products, or one 16-by-32 product, complete in a single cycle. Those operations can therefore be issued back to back, one per clock.

A new operation is accepted either when the unit is idle or during the final cycle of the operation in progress. One operation is then finishing while the next one starts. Result-producing operations return their value on a 64-bit output together with a one-cycle valid strobe. Accumulating operations update the accumulator instead. Two further operations read the accumulator and write it.

Top module: `mac_iter_unit`

## Requirements
- R1: After a synchronous active-low reset, `issue_rdy` is 1, `res_vld` is 0 and the accumulator holds zero.
- R2: An operation is accepted on a rising clock edge where `issue_vld` and `issue_rdy` are both 1. A raised `issue_vld` while `issue_rdy` is 0 has no effect on results or on the accumulator.
- R3: Codes 0, 1 and 2 take 1 cycle when `opnd_b` lies in [-2^15, 2^15-1], 2 cycles when it lies in [-2^23, 2^23-1], and 3 cycles otherwise. All other codes take 1 cycle. An operation accepted at edge E finishes at edge E+N, and `res_vld` is high for exactly the following cycle.
- R4: `issue_rdy` is 1 while the unit is idle and during the last cycle of the operation in progress, and is 0 otherwise. Single-cycle operations can therefore be accepted on every edge.
- R5: Code 0 returns the low 32 bits of the signed product a*b in `res_data[31:0]`, with `res_data[63:32]` equal to zero.
- R6: Code 1 returns the full 64-bit signed product a*b.
- R7: Code 2 adds a*b to the accumulator modulo 2^40 and produces no result strobe.
- R8: Code 3 adds the signed product of `opnd_a[15:0]` and the full 32-bit `opnd_b` to the accumulator modulo 2^40, with no result strobe.
- R9: Code 4 adds a[15:0]*b[15:0] + a[31:16]*b[31:16] to the accumulator modulo 2^40, with all four halves taken as signed values, and produces no result strobe.
- R10: Code 5 returns the accumulator with bit 39 copied into `res_data[63:40]`.
- R11: Code 6 loads the accumulator with {b[7:0], a} and produces no result strobe.
- R12: Every operation sees the accumulator as updated by all operations accepted before it, including the operation that completes on the same edge at which it is accepted.
- R13: Code 7 takes one cycle and changes neither the accumulator nor the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| issue_vld | input | 1 | Operation offered |
| issue_rdy | output | 1 | Unit can accept an operation this cycle |
| issue_op | input | 3 | Operation code (0..7, see requirements) |
| opnd_a | input | 32 | First source operand |
| opnd_b | input | 32 | Second source operand; its magnitude sets the cycle count |
| res_vld | output | 1 | `res_data` is valid this cycle |
| res_data | output | 64 | Result word |

## Verification
The assertions assume only that `issue_op`, `opnd_a` and `opnd_b` are defined whenever `issue_vld` is high. They make no assumption about how an offer is held. An offer may be withdrawn or changed while `issue_rdy` is low, and the unit must ignore it. The stimulus drives defined values on every cycle after reset. It deliberately raises offers during busy cycles and then drops them before they could be accepted. Operand values are chosen at each range boundary of the cycle-count rule, at the most negative 32-bit and 16-bit values, and at the 40-bit wrap point of the accumulator.

// File: rtl/mac_pkg.sv
// mac_pkg: operation codes and classification helpers shared by the
// iterative multiply-accumulate unit. Assumes a 3-bit opcode space.
package mac_pkg;

    typedef enum logic [2:0] {
        OP_MUL   = 3'd0,
        OP_MULL  = 3'd1,
        OP_MLA   = 3'd2,
        OP_MAC16 = 3'd3,
        OP_MACD  = 3'd4,
        OP_ARD   = 3'd5,
        OP_AWR   = 3'd6,
        OP_NOP   = 3'd7
    } mac_op_e;

    // True for operations that drive the result port.
    function automatic logic op_has_result(mac_op_e op);
        return (op == OP_MUL) || (op == OP_MULL) || (op == OP_ARD);
    endfunction

    // True for operations that add their product into the accumulator.
    function automatic logic op_adds_acc(mac_op_e op);
        return (op == OP_MLA) || (op == OP_MAC16) || (op == OP_MACD);
    endfunction

    // True for operations whose cycle count depends on operand size.
    function automatic logic op_is_sized(mac_op_e op);
        return (op == OP_MUL) || (op == OP_MULL) || (op == OP_MLA);
    endfunction

endpackage

// File: rtl/mac_len_sel.sv
// mac_len_sel: picks the number of slice-multiply cycles for an operation.
// Assumes OPW is a multiple of 4. A sized operation needs one cycle when
// opnd_b is a sign-extended LO-bit value, two when it is a sign-extended
// (LO+QW)-bit value, and three otherwise. Every other operation needs one.
module mac_len_sel
    import mac_pkg::*;
#(
    parameter int OPW = 32
) (
    input  mac_op_e          op,
    input  logic [OPW-1:0]   b,
    output logic [1:0]       steps
);
    localparam int LO = OPW / 2;
    localparam int QW = OPW / 4;
    localparam int MID = LO + QW;

    logic fits_lo;
    logic fits_mid;

    // Sign-copy test on the upper bits of the second operand.
    always_comb begin
        fits_lo  = (b[OPW-1:LO-1] == '0) || (b[OPW-1:LO-1] == '1);
        fits_mid = (b[OPW-1:MID-1] == '0) || (b[OPW-1:MID-1] == '1);
    end

    // Cycle count selection.
    always_comb begin
        if (!op_is_sized(op) || fits_lo)
            steps = 2'd1;
        else if (fits_mid)
            steps = 2'd2;
        else
            steps = 2'd3;
    end
endmodule

// File: rtl/mac_slice_mult.sv
// mac_slice_mult: combinational partial product for one iteration step.
// Step 0 takes the low LO bits of the multiplier operand, steps 1 and 2 take
// one QW-bit slice each. Only the last slice is signed, which keeps the sum
// of all steps equal to the signed product. For the 16x32 form the roles of
// the operands swap so that one step suffices. The packed dual form adds a
// second 16x16 product. Assumes cnt < nsteps.
module mac_slice_mult
    import mac_pkg::*;
#(
    parameter int OPW = 32
) (
    input  mac_op_e              op,
    input  logic [OPW-1:0]       a,
    input  logic [OPW-1:0]       b,
    input  logic [1:0]           cnt,
    input  logic [1:0]           nsteps,
    output logic [2*OPW-1:0]     partial
);
    localparam int LO  = OPW / 2;
    localparam int QW  = OPW / 4;
    localparam int CW  = LO + 1;
    localparam int PPW = OPW + CW;
    localparam int RW  = 2 * OPW;
    localparam int DW  = 2 * LO + 1;
    localparam int SHW = $clog2(OPW);

    logic [OPW-1:0]        mcand;
    logic [CW-1:0]         chunk;
    logic [SHW-1:0]        sh;
    logic signed [PPW-1:0] m_ext;
    logic signed [PPW-1:0] c_ext;
    logic signed [PPW-1:0] pp;
    logic signed [DW-1:0]  d_lo_a, d_lo_b, d_hi_a, d_hi_b, d_sum;
    logic [RW-1:0]         main_term;
    logic [RW-1:0]         dual_term;

    // Operand and slice selection for the current step.
    always_comb begin
        mcand = a;
        chunk = '0;
        sh    = '0;
        unique case (cnt)
            2'd0: chunk = (nsteps == 2'd1) ? {b[LO-1], b[LO-1:0]} : {1'b0, b[LO-1:0]};
            2'd1: begin
                chunk = (nsteps == 2'd2) ? {{(CW-QW){b[LO+QW-1]}}, b[LO+QW-1:LO]}
                                         : {{(CW-QW){1'b0}}, b[LO+QW-1:LO]};
                sh    = SHW'(LO);
            end
            default: begin
                chunk = {{(CW-QW){b[OPW-1]}}, b[OPW-1:LO+QW]};
                sh    = SHW'(LO + QW);
            end
        endcase
        if (op == OP_MAC16 || op == OP_MACD) begin
            mcand = (op == OP_MAC16) ? b : {{(OPW-LO){b[LO-1]}}, b[LO-1:0]};
            chunk = {a[LO-1], a[LO-1:0]};
            sh    = '0;
        end
    end

    // Shared slice multiplier, sign-extended and aligned.
    always_comb begin
        m_ext     = {{(PPW-OPW){mcand[OPW-1]}}, mcand};
        c_ext     = {{(PPW-CW){chunk[CW-1]}}, chunk};
        pp        = m_ext * c_ext;
        main_term = {{(RW-PPW){pp[PPW-1]}}, pp} << sh;
    end

    // Upper-half product for the packed dual form.
    always_comb begin
        d_lo_a = '0;
        d_lo_b = '0;
        d_hi_a = {{(DW-LO){a[OPW-1]}}, a[OPW-1:LO]};
        d_hi_b = {{(DW-LO){b[OPW-1]}}, b[OPW-1:LO]};
        d_sum  = d_hi_a * d_hi_b + d_lo_a * d_lo_b;
        dual_term = (op == OP_MACD) ? {{(RW-DW){d_sum[DW-1]}}, d_sum} : '0;
    end

    // Step contribution.
    always_comb partial = main_term + dual_term;
endmodule

// File: rtl/mac_accum.sv
// mac_accum: the wide accumulator register. Adds a value modulo 2^ACCW or
// loads a value. Assumes add_en and wr_en are never high together.
module mac_accum #(
    parameter int ACCW = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            add_en,
    input  logic [ACCW-1:0] add_val,
    input  logic            wr_en,
    input  logic [ACCW-1:0] wr_val,
    output logic [ACCW-1:0] acc
);
    logic [ACCW-1:0] acc_q;

    // Accumulator update: wrap-around add or direct load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (wr_en)
            acc_q <= wr_val;
        else if (add_en)
            acc_q <= acc_q + add_val;
    end

    assign acc = acc_q;

    // R13
    acc_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!add_en && !wr_en) |=> $stable(acc_q));

    // R11
    acc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (acc_q == $past(wr_val)));

    // R7
    acc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(add_en && wr_en));
endmodule

// File: rtl/mac_iter_unit.sv
// mac_iter_unit: top of the iterative multiply-accumulate unit. It holds one
// operation at a time in its iteration engine and accepts the next one during
// the final step, so two operations overlap at the hand-over edge. Results
// and accumulator updates are registered at the edge that ends the last step.
// Assumes ACCW lies between OPW+1 and 2*OPW.
module mac_iter_unit
    import mac_pkg::*;
#(
    parameter int OPW  = 32,
    parameter int ACCW = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld,
    output logic              issue_rdy,
    input  logic [2:0]        issue_op,
    input  logic [OPW-1:0]    opnd_a,
    input  logic [OPW-1:0]    opnd_b,
    output logic              res_vld,
    output logic [2*OPW-1:0]  res_data
);
    localparam int RW   = 2 * OPW;
    localparam int HIGW = ACCW - OPW;

    mac_op_e          in_op;
    logic [1:0]       in_steps;
    logic             busy_q;
    logic [1:0]       cnt_q;
    logic [1:0]       nsteps_q;
    mac_op_e          op_q;
    logic [OPW-1:0]   a_q;
    logic [OPW-1:0]   b_q;
    logic [RW-1:0]    psum_q;
    logic [RW-1:0]    partial;
    logic [RW-1:0]    step_sum;
    logic             last_step;
    logic             accept;
    logic [ACCW-1:0]  acc;
    logic             acc_add;
    logic             acc_wr;
    logic             res_vld_q;
    logic [RW-1:0]    res_q;

    assign in_op = mac_op_e'(issue_op);

    mac_len_sel #(.OPW(OPW)) len_i (
        .op    (in_op),
        .b     (opnd_b),
        .steps (in_steps)
    );

    mac_slice_mult #(.OPW(OPW)) mult_i (
        .op      (op_q),
        .a       (a_q),
        .b       (b_q),
        .cnt     (cnt_q),
        .nsteps  (nsteps_q),
        .partial (partial)
    );

    // Handshake and step tracking.
    always_comb begin
        last_step = busy_q && (cnt_q == nsteps_q - 2'd1);
        issue_rdy = !busy_q || last_step;
        accept    = issue_vld && issue_rdy;
        step_sum  = psum_q + partial;
        acc_add   = last_step && op_adds_acc(op_q);
        acc_wr    = last_step && (op_q == OP_AWR);
    end

    // Iteration engine: load on accept, otherwise advance one slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            cnt_q    <= '0;
            nsteps_q <= 2'd1;
            op_q     <= OP_NOP;
            a_q      <= '0;
            b_q      <= '0;
            psum_q   <= '0;
        end else if (accept) begin
            busy_q   <= 1'b1;
            cnt_q    <= '0;
            nsteps_q <= in_steps;
            op_q     <= in_op;
            a_q      <= opnd_a;
            b_q      <= opnd_b;
            psum_q   <= '0;
        end else if (last_step) begin
            busy_q   <= 1'b0;
        end else if (busy_q) begin
            cnt_q    <= cnt_q + 2'd1;
            psum_q   <= step_sum;
        end
    end

    mac_accum #(.ACCW(ACCW)) acc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (acc_add),
        .add_val (step_sum[ACCW-1:0]),
        .wr_en   (acc_wr),
        .wr_val  ({b_q[HIGW-1:0], a_q}),
        .acc     (acc)
    );

    // Result register and one-cycle valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld_q <= 1'b0;
            res_q     <= '0;
        end else begin
            res_vld_q <= last_step && op_has_result(op_q);
            if (last_step) begin
                unique case (op_q)
                    OP_MUL:  res_q <= {{(RW-OPW){1'b0}}, step_sum[OPW-1:0]};
                    OP_MULL: res_q <= step_sum;
                    OP_ARD:  res_q <= {{(RW-ACCW){acc[ACCW-1]}}, acc};
                    default: res_q <= res_q;
                endcase
            end
        end
    end

    assign res_vld  = res_vld_q;
    assign res_data = res_q;

    // R2
    accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_rdy) |=> (busy_q && cnt_q == 2'd0));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !issue_rdy) |=> (busy_q && $stable(a_q) && $stable(b_q) && $stable(op_q)));

    // R3
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < nsteps_q && nsteps_q != 2'd0));

    // R3
    res_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> $past(busy_q));
endmodule

// File: tb/mac_iter_unit_tb_top.sv
module mac_iter_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OPW  = 32;
    localparam int ACCW = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              issue_vld = 1'b0;
    logic              issue_rdy;
    logic [2:0]        issue_op = 3'd7;
    logic [OPW-1:0]    opnd_a = '0;
    logic [OPW-1:0]    opnd_b = '0;
    logic              res_vld;
    logic [2*OPW-1:0]  res_data;

    mac_iter_unit #(.OPW(OPW), .ACCW(ACCW)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_rdy(issue_rdy),
        .issue_op(issue_op), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .res_vld(res_vld), .res_data(res_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference state.
    int               n_cmp = 0;
    int               n_bad = 0;
    int               edge_n = 0;
    bit               m_busy = 0;
    int               m_end = 0;
    int               m_op = 7;
    logic signed [31:0] m_a = '0;
    logic signed [31:0] m_b = '0;
    logic [ACCW-1:0]  m_acc = '0;
    bit               exp_vld = 0;
    logic [63:0]      exp_data = '0;
    bit               exp_rdy = 1;
    bit               last_acc = 0;
    string            phase = "R1";

    function automatic int ref_steps(int op, logic signed [31:0] b);
        if (op > 2) return 1;
        if (b >= -32768 && b <= 32767) return 1;
        if (b >= -8388608 && b <= 8388607) return 2;
        return 3;
    endfunction

    function automatic string op_tag(int op);
        case (op)
            0: return "R5";
            1: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic finish_ref();
        longint sa, sb, p, x, y;
        logic [63:0] pv;
        sa = longint'(m_a);
        sb = longint'(m_b);
        p  = sa * sb;
        pv = p;
        case (m_op)
            0: begin exp_vld = 1; exp_data = {32'h0, pv[31:0]}; end
            1: begin exp_vld = 1; exp_data = pv; end
            2: m_acc = m_acc + pv[ACCW-1:0];
            3: begin
                x = longint'($signed(m_a[15:0])) * sb;
                pv = x;
                m_acc = m_acc + pv[ACCW-1:0];
            end
            4: begin
                x = longint'($signed(m_a[15:0])) * longint'($signed(m_b[15:0]));
                y = longint'($signed(m_a[31:16])) * longint'($signed(m_b[31:16]));
                pv = x + y;
                m_acc = m_acc + pv[ACCW-1:0];
            end
            5: begin exp_vld = 1; exp_data = {{(64-ACCW){m_acc[ACCW-1]}}, m_acc}; end
            6: m_acc = {m_b[7:0], m_a};
            default: ;
        endcase
    endtask

    // Advance the model by the edge just passed, then compare the ports.
    task automatic step_and_compare();
        edge_n++;
        exp_vld = 0;
        last_acc = 0;
        if (m_busy && m_end == edge_n) begin
            finish_ref();
            m_busy = 0;
        end
        if (issue_vld && exp_rdy) begin
            m_busy = 1;
            m_op = int'(issue_op);
            m_a = opnd_a;
            m_b = opnd_b;
            m_end = edge_n + ref_steps(m_op, opnd_b);
            last_acc = 1;
        end
        exp_rdy = !m_busy || (m_end == edge_n + 1);
        n_cmp++;
        if (issue_rdy !== exp_rdy) begin
            n_bad++;
            $display("FAIL R4 [%s] edge %0d issue_rdy got %b exp %b", phase, edge_n, issue_rdy, exp_rdy);
        end
        n_cmp++;
        if (res_vld !== exp_vld) begin
            n_bad++;
            $display("FAIL R3 [%s] edge %0d res_vld got %b exp %b", phase, edge_n, res_vld, exp_vld);
        end
        if (exp_vld) begin
            n_cmp++;
            if (res_data !== exp_data) begin
                n_bad++;
                $display("FAIL %s [%s] edge %0d res_data got %h exp %h", op_tag(m_op), phase, edge_n, res_data, exp_data);
            end
        end
    endtask

    task automatic drive_cycle(bit v, int op, logic [31:0] a, logic [31:0] b);
        issue_vld = v;
        issue_op  = 3'(op);
        opnd_a    = a;
        opnd_b    = b;
        @(negedge clk);
        step_and_compare();
    endtask

    // R2: keep offering until the model sees the offer accepted.
    task automatic issue(int op, logic [31:0] a, logic [31:0] b);
        forever begin
            drive_cycle(1, op, a, b);
            if (last_acc) break;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive_cycle(0, 7, '0, '0);
    endtask

    function automatic logic [31:0] rand_b();
        logic [31:0] r;
        r = $urandom;
        case ($urandom_range(0, 3))
            0: return {{16{r[15]}}, r[15:0]};
            1: return {{8{r[23]}}, r[23:0]};
            2: return r;
            default: begin
                case ($urandom_range(0, 7))
                    0: return 32'h0000_7FFF;
                    1: return 32'hFFFF_8000;
                    2: return 32'h0000_8000;
                    3: return 32'hFFFF_7FFF;
                    4: return 32'h007F_FFFF;
                    5: return 32'hFF80_0000;
                    6: return 32'h0080_0000;
                    default: return 32'h8000_0000;
                endcase
            end
        endcase
    endfunction

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at edge %0d", edge_n);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs under reset
        n_cmp++;
        if (res_vld !== 1'b0 || issue_rdy !== 1'b1) begin
            n_bad++;
            $display("FAIL R1 reset res_vld got %b exp 0, issue_rdy got %b exp 1", res_vld, issue_rdy);
        end
        rst_n = 1'b1;

        phase = "R1 acc zero";
        issue(5, '0, '0);
        idle(2);

        phase = "R5 R6 R3 boundaries";
        issue(0, 32'd7, 32'h0000_7FFF);
        issue(0, 32'hFFFF_FFFD, 32'hFFFF_8000);
        issue(1, 32'h1234_5678, 32'h0000_8000);
        issue(1, 32'h8000_0000, 32'hFFFF_7FFF);
        issue(0, 32'h0BAD_F00D, 32'h007F_FFFF);
        issue(1, 32'hDEAD_BEEF, 32'hFF80_0000);
        issue(1, 32'h7FFF_FFFF, 32'h0080_0000);
        issue(1, 32'h8000_0000, 32'h8000_0000);
        issue(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        idle(4);

        phase = "R11 R10 sign copy";
        issue(6, 32'h0000_0001, 32'h0000_0080);
        issue(5, '0, '0);
        idle(2);

        phase = "R7 wrap";
        issue(6, 32'hFFFF_FFFF, 32'h0000_007F);
        issue(2, 32'd1, 32'd1);
        issue(5, '0, '0);
        issue(2, 32'h8000_0000, 32'h8000_0000);
        issue(5, '0, '0);
        idle(2);

        phase = "R2 ignored offer";
        issue(2, 32'h0001_0000, 32'h4000_0000);
        drive_cycle(1, 6, 32'hAAAA_AAAA, 32'h0000_0055);
        drive_cycle(0, 6, '0, '0);
        idle(2);
        issue(5, '0, '0);
        idle(2);

        phase = "R8 R9 R12 back-to-back";
        issue(6, '0, '0);
        issue(3, 32'h0000_8000, 32'h7FFF_FFFF);
        issue(3, 32'h0000_7FFF, 32'h8000_0000);
        issue(4, 32'h8000_8000, 32'h8000_8000);
        issue(4, 32'h7FFF_8001, 32'hFFFF_7FFF);
        issue(5, '0, '0);
        issue(2, 32'h0012_3456, 32'h0123_4567);
        issue(5, '0, '0);
        idle(3);

        phase = "R13 no-op";
        issue(7, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        issue(5, '0, '0);
        idle(2);

        phase = "R3 R4 random";
        for (int k = 0; k < 3000; k++) begin
            int op;
            op = $urandom_range(0, 7);
            if (k % 7 == 0) op = 5;
            if ($urandom_range(0, 3) == 0) idle(1);
            if ($urandom_range(0, 5) == 0) drive_cycle(1, 6, $urandom, $urandom);
            issue(op, $urandom, rand_b());
        end
        issue(5, '0, '0);
        idle(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule